// File: doc/BRIEF.md
# Byte-Parity Guarded Single-Port Memory

This block wraps a single-port synchronous memory and keeps one even-parity bit for every 8-bit lane of every word, held in a separate parity store beside the data. A one-bit mode setting turns the guard on or off. With the guard on, each write stores fresh parity for the lanes it touches, and each read recomputes parity over the returned word and compares it with the stored bits. With the guard off, the parity store is frozen: its clock enable is dropped, it keeps its contents, writes do not change it and reads are not checked.

No per-word marker records whether a word's parity is current. Data written while the guard is off can therefore mismatch once the guard is turned on, until software writes that word again with the guard on. A detected mismatch raises a one-cycle error flag alongside the read data. It also sets a sticky status bit and captures the address of the first failing word. Software clears both by writing 1 to a clear bit in the control port.

Top module: `pm_parity_sram`

## Requirements
- R1: After reset the guard is off, `err_sticky` is 0, `err_addr` is 0 and `err_pulse` is 0.
- R2: A read request (`req_valid`=1, `req_we`=0) returns the word on `rd_data` in the cycle after the request. A write with `req_we`=1 updates only the byte lanes whose `req_be` bit is set (bit i covers data bits 8i+7..8i).
- R3: With the guard on, a write stores even parity for each enabled lane, so a later guarded read of that word reports no error.
- R4: With the guard off, writes leave the stored parity bits unchanged, so a word rewritten then with a different lane parity mismatches after the guard is turned on.
- R5: A read issued while the guard is off never raises `err_pulse` and never sets `err_sticky`.
- R6: A read issued while the guard is on raises `err_pulse` for exactly the cycle its data appears on `rd_data` when any lane's recomputed parity differs from the stored bit.
- R7: An error sets `err_sticky` on the next clock edge and captures the failing address in `err_addr`. Later errors do not change `err_addr` while `err_sticky` stays set.
- R8: A control write (`cfg_wr`=1) takes effect on the next edge. `cfg_wdata` bit 0 sets the guard mode (1 = on). Bit 1 set to 1 clears `err_sticky` and zeroes `err_addr`. An error in the same cycle as a clear wins and records its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Memory request strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | DATA_W/8 | Byte-lane write enables |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, one cycle after a read request |
| cfg_wr | input | 1 | Control write strobe |
| cfg_wdata | input | 2 | Bit 0 guard mode, bit 1 write-1-to-clear error status |
| err_pulse | output | 1 | Parity mismatch, aligned with rd_data |
| err_sticky | output | 1 | Sticky error status |
| err_addr | output | ADDR_W | Address of the first captured failing read |

## Verification
The bound checker checks the timing on every cycle. It confirms that an error flag only follows a read issued in guarded mode, that the flag always sets the sticky bit, and that the sticky bit and captured address hold until a clear. Only the bench's scenarios can show whether the stored parity itself is right. Those scenarios cover clean reads after guarded writes, every byte-enable pattern, mismatches left by unguarded writes, and a clear that lands in the same cycle as a new error. They check these against a bench-side model of the data and parity stores.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int LANE_W     = 8;
    localparam int CFG_W      = 2;
    localparam int CFG_EN_BIT = 0;
    localparam int CFG_CLR_BIT = 1;
endpackage

// File: rtl/pm_lane_parity.sv
module pm_lane_parity #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / pm_pkg::LANE_W
) (
    input  logic [DATA_W-1:0] data,
    output logic [LANES-1:0]  par
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign par[i] = ^data[i*pm_pkg::LANE_W +: pm_pkg::LANE_W];
    end
endmodule

// File: rtl/pm_data_array.sv
module pm_data_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / pm_pkg::LANE_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [LANES-1:0]  be,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int LW = pm_pkg::LANE_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < DEPTH; w++) begin
                    mem_q[w][l*LW +: LW] <= '0;
                end
            end else if (wr_en && be[l]) begin
                mem_q[addr][l*LW +: LW] <= wdata[l*LW +: LW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= mem_q[addr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/pm_parity_array.sv
module pm_parity_array #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [LANES-1:0]  be,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  wpar,
    output logic [LANES-1:0]  rpar
);
    logic [LANES-1:0] par_q [DEPTH];
    logic [LANES-1:0] rpar_q;

    // clk_en stands in for the clock gate: with it low nothing here changes.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < DEPTH; w++) begin
                    par_q[w][l] <= 1'b0;
                end
            end else if (clk_en && wr_en && be[l]) begin
                par_q[addr][l] <= wpar[l];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpar_q <= '0;
        end else if (clk_en && rd_en) begin
            rpar_q <= par_q[addr];
        end
    end

    assign rpar = rpar_q;
endmodule

// File: rtl/pm_parity_sram.sv
module pm_parity_sram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / pm_pkg::LANE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_we,
    input  logic [LANES-1:0]        req_be,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic [DATA_W-1:0]       rd_data,
    input  logic                    cfg_wr,
    input  logic [pm_pkg::CFG_W-1:0] cfg_wdata,
    output logic                    err_pulse,
    output logic                    err_sticky,
    output logic [ADDR_W-1:0]       err_addr
);
    typedef struct packed {
        logic              en;
        logic              sticky;
        logic [ADDR_W-1:0] eaddr;
        logic              rd_chk;
        logic [ADDR_W-1:0] rd_addr;
    } state_t;

    state_t st_d, st_q;

    logic             wr_req, rd_req;
    logic [LANES-1:0] wr_par, calc_par, stored_par;
    logic             mismatch;
    logic             chk_en_q;

    assign wr_req = req_valid && req_we;
    assign rd_req = req_valid && !req_we;

    pm_lane_parity #(.DATA_W(DATA_W)) u_wr_par (
        .data (req_wdata),
        .par  (wr_par)
    );

    pm_lane_parity #(.DATA_W(DATA_W)) u_rd_par (
        .data (rd_data),
        .par  (calc_par)
    );

    pm_data_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_req),
        .rd_en (rd_req),
        .be    (req_be),
        .addr  (req_addr),
        .wdata (req_wdata),
        .rdata (rd_data)
    );

    pm_parity_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_par (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (st_q.en),
        .wr_en  (wr_req),
        .rd_en  (rd_req),
        .be     (req_be),
        .addr   (req_addr),
        .wpar   (wr_par),
        .rpar   (stored_par)
    );

    assign mismatch  = |(calc_par ^ stored_par);
    assign err_pulse = st_q.rd_chk && mismatch;

    always_comb begin
        st_d         = st_q;
        st_d.rd_chk  = rd_req && st_q.en;
        st_d.rd_addr = req_addr;
        if (cfg_wr) begin
            st_d.en = cfg_wdata[pm_pkg::CFG_EN_BIT];
            if (cfg_wdata[pm_pkg::CFG_CLR_BIT]) begin
                st_d.sticky = 1'b0;
                st_d.eaddr  = '0;
            end
        end
        if (err_pulse && (!st_q.sticky || (cfg_wr && cfg_wdata[pm_pkg::CFG_CLR_BIT]))) begin
            st_d.sticky = 1'b1;
            st_d.eaddr  = st_q.rd_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_sticky = st_q.sticky;
    assign err_addr   = st_q.eaddr;
    assign chk_en_q   = st_q.en;
endmodule

module pm_parity_sram_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_we,
    input logic              cfg_wr,
    input logic [1:0]        cfg_wdata,
    input logic              chk_en,
    input logic              err_pulse,
    input logic              err_sticky,
    input logic [ADDR_W-1:0] err_addr
);
    logic clr;
    assign clr = cfg_wr && cfg_wdata[1];

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!err_sticky && err_addr == '0 && !chk_en));

    a_r5_no_err_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(chk_en));

    a_r6_err_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(req_valid && !req_we));

    a_r7_err_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> err_sticky);

    a_r7_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sticky && !clr) |=> (err_sticky && $stable(err_addr)));

    a_r8_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !err_pulse) |=> (!err_sticky && err_addr == '0));
endmodule

bind pm_parity_sram pm_parity_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_we     (req_we),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .chk_en     (chk_en_q),
    .err_pulse  (err_pulse),
    .err_sticky (err_sticky),
    .err_addr   (err_addr)
);

// File: tb/tb_pm_parity_sram.sv
module tb_pm_parity_sram;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int NL = DW / 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_we;
    logic [NL-1:0] req_be;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata, rd_data;
    logic          cfg_wr;
    logic [1:0]    cfg_wdata;
    logic          err_pulse, err_sticky;
    logic [AW-1:0] err_addr;

    int nchk = 0;
    int nerr = 0;

    logic [DW-1:0] mem_m [DEPTH];
    logic [NL-1:0] par_m [DEPTH];
    logic          en_m, st_m;
    logic [AW-1:0] ea_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_parity_sram #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .err_pulse(err_pulse), .err_sticky(err_sticky), .err_addr(err_addr)
    );

    function automatic logic [NL-1:0] lpar(input logic [DW-1:0] d);
        logic [NL-1:0] p;
        for (int i = 0; i < NL; i++) p[i] = ^d[i*8 +: 8];
        return p;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d, input logic [NL-1:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = AW'(a); req_wdata = d; req_be = be;
        for (int l = 0; l < NL; l++) begin
            if (be[l]) begin
                mem_m[a][l*8 +: 8] = d[l*8 +: 8];
                if (en_m) par_m[a][l] = ^d[l*8 +: 8];
            end
        end
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic rd(input int a, input string tag);
        logic exp_err;
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = AW'(a);
        exp_err = en_m && (lpar(mem_m[a]) != par_m[a]);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R2 data"}, rd_data, mem_m[a]);
        chk({tag, " R6 pulse"}, DW'(err_pulse), DW'(exp_err));
        if (exp_err && !st_m) begin st_m = 1'b1; ea_m = AW'(a); end
        @(negedge clk);
        chk({tag, " R7 sticky"}, DW'(err_sticky), DW'(st_m));
        chk({tag, " R7 addr"}, DW'(err_addr), DW'(ea_m));
    endtask

    task automatic cfg(input logic en, input logic clr);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = {clr, en};
        en_m = en;
        if (clr) begin st_m = 1'b0; ea_m = '0; end
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return (DW'(a) * 32'h0103_0507) ^ 32'h80C0_E0F1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_be = '0;
        req_addr = '0; req_wdata = '0; cfg_wr = 1'b0; cfg_wdata = '0;
        en_m = 1'b0; st_m = 1'b0; ea_m = '0;
        for (int i = 0; i < DEPTH; i++) begin mem_m[i] = '0; par_m[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sticky", DW'(err_sticky), 0);
        chk("R1 addr", DW'(err_addr), 0);
        chk("R1 pulse", DW'(err_pulse), 0);

        // R5: guard off after reset; an odd-parity word written now is never flagged
        wr(3, 32'h0000_0001, '1);
        rd(3, "R1 R5 off-after-reset");

        // R3: guarded writes then clean guarded reads over every word
        cfg(1'b1, 1'b0);
        for (int a = 0; a < DEPTH; a++) wr(a, pat(a), '1);
        for (int a = 0; a < DEPTH; a++) rd(a, "R3 sweep");

        // R2/R3: every byte-enable pattern on one word
        for (int b = 0; b < (1 << NL); b++) begin
            wr(5, 32'h5A00_0000 ^ (DW'(b) * 32'h0011_2233), NL'(b));
            rd(5, "R2 R3 be");
        end

        // R4/R5: unguarded rewrites; even words flip one lane's parity
        cfg(1'b0, 1'b0);
        for (int a = 0; a < DEPTH; a++) begin
            if (a % 2 == 0) wr(a, pat(a) ^ (32'h1 << ((a * 2) % 32)), '1);
            else            wr(a, pat(a) ^ 32'h3, '1);
        end
        for (int a = 0; a < DEPTH; a++) rd(a, "R5 off");

        // R4/R6/R7: guard on, stale parity flagged, first address kept
        cfg(1'b1, 1'b0);
        for (int a = 0; a < DEPTH; a++) rd(a, "R4 R6 R7 stale");

        // R8: clear, then a fresh error records its own address
        cfg(1'b1, 1'b1);
        chk("R8 cleared sticky", DW'(err_sticky), 0);
        chk("R8 cleared addr", DW'(err_addr), 0);
        rd(2, "R7 after clear");

        // R8: clear in the same cycle as a new error; error wins
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = AW'(4);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 coincide pulse", DW'(err_pulse), 1);
        cfg_wr = 1'b1; cfg_wdata = 2'b11;
        @(negedge clk);
        cfg_wr = 1'b0;
        st_m = 1'b1; ea_m = AW'(4);
        chk("R8 coincide sticky", DW'(err_sticky), 1);
        chk("R8 coincide addr", DW'(err_addr), 4);

        // R3: rewriting a stale word with the guard on repairs it
        cfg(1'b1, 1'b1);
        wr(4, pat(4) ^ 32'h10, '1);
        rd(4, "R3 repaired");

        // R5: guard off again, stale word read without error
        cfg(1'b0, 1'b0);
        rd(6, "R5 off again");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule